// File: doc/BRIEF.md
# Framed Serial Sample Output Port

This block takes a 16-bit sample, presented as a parallel word with a one-cycle valid pulse, and sends it out on a single serial line. A gated output clock and an active-low frame strobe go with the line. A burst starts when the port is idle and a valid pulse arrives. The strobe falls, and the first bit is driven, on the first rising edge of the output clock. Sixteen clock pulses then carry the word, most significant bit first. Half a clock period after the last falling edge, the strobe and the line both return high and the clock stays low.

All logic runs on a single system clock. The output clock is built from it by a divider. The half-period of the divider is selected per burst, and the fastest setting gives an output clock of half the system clock rate. A disable input is not tied to the clock. While it is high, the three serial pins float at high impedance. The burst keeps running inside the block during that time, so any bits that fall in the window are lost rather than delayed. A valid pulse that arrives while a burst is running is dropped, and it sets a sticky overrun flag.

Top module: `framed_serial_tx`

## Requirements
- R1: After reset, with the port enabled, the serial line is high, the frame strobe is high, the output clock is low and the overrun flag is 0.
- R2: A valid pulse seen at a clock edge while the port is idle captures the word. After one half-period of the output clock, the strobe falls and the output clock rises at the same system clock edge, and the line carries bit 15.
- R3: Bits go out most significant first. The line changes only on rising edges of the output clock, and the n-th rising edge (n = 1..16) drives bit 16-n.
- R4: Every burst has exactly 16 output-clock pulses. The output clock is low whenever the frame strobe is high.
- R5: One half-period after the 16th falling edge of the output clock, the strobe and the line both go high, and the output clock makes no further pulse.
- R6: Between bursts the line and the strobe stay high until the next burst starts.
- R7: The 2-bit ratio input s sets the half-period to 2^s system clock cycles, so s=0 gives an output clock at half the system clock rate. The value is captured when a burst starts, and later changes to it have no effect on that burst.
- R8: While the disable input is high, the line, the strobe and the output clock are at high impedance. This takes effect at once, with no clock edge needed, including during a burst.
- R9: The burst timing keeps running while the port is disabled. Bits due inside the window are lost. After the disable falls, the pins show the values they would have had if the port had never been disabled.
- R10: A valid pulse during a burst does not change the burst in progress and sets the overrun flag. The flag stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleWord | input | 16 | Parallel word to send |
| sampleValid | input | 1 | One-cycle pulse that offers sampleWord |
| ratioSel | input | 2 | Half-period select, 2^ratioSel system clock cycles |
| outDisable | input | 1 | Asynchronous disable; high puts the serial pins at high impedance |
| serData | output | 1 | Serial line, idles high |
| serFrameN | output | 1 | Active-low frame strobe |
| serClk | output | 1 | Gated output clock, idles low |
| overrun | output | 1 | Sticky flag for a valid pulse dropped during a burst |

## Verification
The assertions assume that sampleValid and ratioSel are synchronous to clk and settle before each edge. The bench meets this by changing them only on falling edges of clk. They do not cover the disable input, because that input only acts on the pin drivers. Its effect is checked at the pins with four-state compares against Z, using windows that start inside a burst, that cover the end of a burst, and that end after the port has gone idle. Valid pulses during a burst, and ratio changes during a burst, are also driven only on falling edges, at cycle offsets where the block is known to be busy.

// File: rtl/fstx_pkg.sv
package fstx_pkg;
  // Strobes from the control to the datapath.
  typedef struct packed {
    logic load;    // capture the parallel word
    logic rise;    // output clock rising edge, next bit onto the line
    logic fall;    // output clock falling edge
    logic finish;  // end of burst, return pins to idle
  } fstx_strobe_t;
endpackage

// File: rtl/fstx_divider.sv
module fstx_divider #(
  parameter int RATIO_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               restart,
  input  logic               run,
  input  logic [RATIO_W-1:0] ratio,
  output logic               tick
);
  localparam int MAX_SHIFT = (1 << RATIO_W) - 1;
  localparam int CNT_W     = MAX_SHIFT + 1;

  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] halfM1;

  always_comb begin
    halfM1 = (CNT_W'(1) << ratio) - CNT_W'(1);
    tick   = run && (divCnt == halfM1);
  end

  always_ff @(posedge clk) begin
    if (!rstN || restart) begin
      divCnt <= '0;
    end else if (run) begin
      divCnt <= tick ? '0 : divCnt + CNT_W'(1);
    end
  end

  // R7: the counter never passes the selected half-period.
  a_r7_div_bound: assert property (@(posedge clk) disable iff (!rstN)
    run |-> (divCnt <= halfM1));
endmodule

// File: rtl/fstx_ctrl.sv
module fstx_ctrl
  import fstx_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int RATIO_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleValid,
  input  logic [RATIO_W-1:0] ratioSel,
  output fstx_strobe_t       strobe,
  output logic               overrun
);
  localparam int EDGE_LAST = 2 * WORD_W;
  localparam int EDGE_W    = $clog2(EDGE_LAST + 1);
  localparam logic [EDGE_W-1:0] EDGE_END = EDGE_W'(EDGE_LAST);

  typedef enum logic {ST_IDLE, ST_BUSY} fstx_state_t;

  fstx_state_t        state;
  logic [RATIO_W-1:0] ratioQ;
  logic [EDGE_W-1:0]  edgeCnt;
  logic               tick;
  logic               busy;
  logic               loadNow;

  assign busy    = (state == ST_BUSY);
  assign loadNow = !busy && sampleValid;

  fstx_divider #(.RATIO_W(RATIO_W)) u_div (
    .clk    (clk),
    .rstN   (rstN),
    .restart(loadNow),
    .run    (busy),
    .ratio  (ratioQ),
    .tick   (tick)
  );

  always_comb begin
    strobe        = '0;
    strobe.load   = loadNow;
    strobe.finish = tick && (edgeCnt == EDGE_END);
    strobe.rise   = tick && (edgeCnt != EDGE_END) && !edgeCnt[0];
    strobe.fall   = tick && (edgeCnt != EDGE_END) &&  edgeCnt[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      ratioQ  <= '0;
      edgeCnt <= '0;
      overrun <= 1'b0;
    end else begin
      if (busy && sampleValid) overrun <= 1'b1;
      unique case (state)
        ST_IDLE: if (loadNow) begin
          state   <= ST_BUSY;
          ratioQ  <= ratioSel;
          edgeCnt <= '0;
        end
        ST_BUSY: if (strobe.finish) begin
          state <= ST_IDLE;
        end else if (tick) begin
          edgeCnt <= edgeCnt + EDGE_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);
  a_r10_drop_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    (busy && sampleValid) |=> overrun);
  a_r4_edge_bound: assert property (@(posedge clk) disable iff (!rstN)
    edgeCnt <= EDGE_END);
  a_r7_ratio_held: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(ratioQ));
endmodule

// File: rtl/fstx_datapath.sv
module fstx_datapath
  import fstx_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  fstx_strobe_t      strobe,
  input  logic [WORD_W-1:0] sampleWord,
  output logic              dataQ,
  output logic              frameNQ,
  output logic              clkQ
);
  logic [WORD_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      dataQ    <= 1'b1;
      frameNQ  <= 1'b1;
      clkQ     <= 1'b0;
    end else begin
      if (strobe.load) shiftReg <= sampleWord;
      if (strobe.rise) begin
        dataQ    <= shiftReg[WORD_W-1];
        shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
        clkQ     <= 1'b1;
        frameNQ  <= 1'b0;
      end
      if (strobe.fall) clkQ <= 1'b0;
      if (strobe.finish) begin
        dataQ   <= 1'b1;
        frameNQ <= 1'b1;
        clkQ    <= 1'b0;
      end
    end
  end

  // R3: the line moves only with a rising edge or the end of a burst.
  a_r3_data_steady: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.rise && !strobe.finish) |=> $stable(dataQ));
  // R4: no output clock pulse outside a frame.
  a_r4_clk_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    frameNQ |-> !clkQ);
  // R5: the strobe releases with the line high and the clock low.
  a_r5_release_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameNQ) |-> (dataQ && !clkQ));
endmodule

// File: rtl/framed_serial_tx.sv
module framed_serial_tx
  import fstx_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int RATIO_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WORD_W-1:0]  sampleWord,
  input  logic               sampleValid,
  input  logic [RATIO_W-1:0] ratioSel,
  input  logic               outDisable,
  output logic               serData,
  output logic               serFrameN,
  output logic               serClk,
  output logic               overrun
);
  fstx_strobe_t strobe;
  logic dataQ;
  logic frameNQ;
  logic clkQ;

  fstx_ctrl #(.WORD_W(WORD_W), .RATIO_W(RATIO_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .ratioSel   (ratioSel),
    .strobe     (strobe),
    .overrun    (overrun)
  );

  fstx_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .sampleWord(sampleWord),
    .dataQ     (dataQ),
    .frameNQ   (frameNQ),
    .clkQ      (clkQ)
  );

  // R8: combinational pin release, not tied to any clock edge.
  assign serData   = outDisable ? 1'bz : dataQ;
  assign serFrameN = outDisable ? 1'bz : frameNQ;
  assign serClk    = outDisable ? 1'bz : clkQ;
endmodule

// File: tb/framed_serial_tx_tb.sv
module framed_serial_tx_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] sampleWord = '0;
  logic        sampleValid = 1'b0;
  logic [1:0]  ratioSel = '0;
  logic        outDisable = 1'b0;
  wire         serData;
  wire         serFrameN;
  wire         serClk;
  wire         overrun;

  int nChecks = 0;
  int nFails  = 0;
  logic expOverrun = 1'b0;

  always #5 clk = ~clk;

  framed_serial_tx u_dut (
    .clk(clk), .rstN(rstN), .sampleWord(sampleWord), .sampleValid(sampleValid),
    .ratioSel(ratioSel), .outDisable(outDisable), .serData(serData),
    .serFrameN(serFrameN), .serClk(serClk), .overrun(overrun)
  );

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Expected pins t ticks after load: tick t (1..32) toggles the clock,
  // rising edge n drives bit 16-n (R3), tick 33 returns idle (R5).
  task automatic checkPins(input string req, input logic [15:0] w, input int t, input logic dis);
    logic eClk, eFrm, eDat;
    if (t >= 1 && t <= 32) begin
      eClk = t[0];
      eFrm = 1'b0;
      eDat = w[15 - (t - 1) / 2];
    end else begin
      eClk = 1'b0;
      eFrm = 1'b1;
      eDat = 1'b1;
    end
    if (dis) begin
      eClk = 1'bz; eFrm = 1'bz; eDat = 1'bz;
    end
    check({req, " data"},  serData,   eDat);
    check({req, " frame"}, serFrameN, eFrm);
    check({req, " clk"},   serClk,    eClk);
  endtask

  // One burst. disLo/disHi: cycle window with the disable high (R8, R9).
  // pokeAt: cycle where a foreign valid and ratio arrive mid-burst (R7, R10).
  task automatic runBurst(input logic [15:0] w, input int r,
                          input int disLo, input int disHi, input int pokeAt);
    int h;
    h = 1 << r;
    @(negedge clk);
    sampleWord  = w;
    ratioSel    = 2'(r);
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    sampleWord  = ~w;
    #1;
    checkPins("R2 pre", w, 0, 1'b0);
    for (int k = 1; k <= 33 * h + 2; k++) begin
      @(negedge clk);
      sampleValid = (k == pokeAt);
      if (k == pokeAt) begin
        ratioSel   = 2'(r) + 2'd1;
        expOverrun = 1'b1;
      end
      outDisable = (k >= disLo && k < disHi);
      #1;
      if (outDisable || (k >= disHi && disHi > 0))
        checkPins("R9 R8", w, k / h, outDisable);
      else if (k / h == 0)
        checkPins("R2", w, 0, 1'b0);
      else if (k / h <= 32)
        checkPins("R3 R7", w, k / h, 1'b0);
      else
        checkPins("R5 R6", w, k / h, 1'b0);
    end
    sampleValid = 1'b0;
    outDisable  = 1'b0;
    #1;
    check("R10 overrun", overrun, expOverrun);
  endtask

  initial begin
    #1_500_000;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check("R1 data", serData, 1'b1);
    check("R1 frame", serFrameN, 1'b1);
    check("R1 clk", serClk, 1'b0);
    check("R1 overrun", overrun, 1'b0);

    // Ratio sweep with several bit patterns (R2, R3, R4, R5, R7).
    for (int r = 0; r < 4; r++) begin
      runBurst(16'hA5C3, r, 0, 0, 0);
      runBurst(16'h8000, r, 0, 0, 0);
      runBurst(16'h0001, r, 0, 0, 0);
      runBurst(16'h5A3C ^ 16'(r * 16'h1111), r, 0, 0, 0);
    end
    runBurst(16'hFFFF, 0, 0, 0, 0);
    runBurst(16'h0000, 0, 0, 0, 0);

    // R6: idle gap keeps line and strobe high.
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); #1;
      check("R6 idle data", serData, 1'b1);
      check("R6 idle frame", serFrameN, 1'b1);
    end

    // R8 R9: disable mid-burst, across burst end, and while idle.
    runBurst(16'hC0DE, 1, 10, 30, 0);
    runBurst(16'h1234, 0, 20, 40, 0);
    runBurst(16'hBEEF, 2, 1, 3, 0);

    // R10 and R7: foreign valid and ratio change mid-burst.
    runBurst(16'h9E37, 1, 0, 0, 12);
    runBurst(16'h0F0F, 0, 0, 0, 0);
    runBurst(16'h7001, 0, 0, 0, 32);

    // R10: the flag clears only on reset.
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    expOverrun = 1'b0;
    #1;
    check("R10 cleared by reset", overrun, 1'b0);
    check("R1 frame after reset", serFrameN, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule